// File: doc/BRIEF.md
# Operand Bypass and Load-Dependency Stall Control

This block holds the hazard decisions of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). For each of the two ALU operands sitting in the execute stage, it picks where the operand value comes from. The choices are the register-file read, the result held in the EX/MEM pipeline register, or the result held in the MEM/WB pipeline register. The younger EX/MEM result wins when both later stages hold a matching write. Writes aimed at register zero are never bypassed.

The second half watches for a load in the execute stage whose destination is read by the instruction now in decode. When it sees one, it holds the program counter and the IF/ID register for one cycle. In that same cycle it replaces the control bundle going into ID/EX with all zeros, so that a bubble enters execute. A one-bit memory of the previous decision keeps any stall to a single cycle, even if the hazard inputs stay the same.

All decisions are combinational in the cycle the pipeline registers present their fields. The only state is the one-bit stall memory.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: When `exm_wr_en` is 1, `exm_dst` is non-zero and `exm_dst` equals an operand's source index (`ex_src_a` for operand A, `ex_src_b` for operand B), that operand's select is 2'b10.
- R2: When R1 does not apply to an operand but `wbk_wr_en` is 1, `wbk_dst` is non-zero and `wbk_dst` equals that operand's source index, the select is 2'b01.
- R3: When both later stages match the same operand, the EX/MEM source (2'b10) is chosen. The value 2'b11 never appears.
- R4: A destination index of 0 never causes forwarding, even when the write enable is set. The select stays 2'b00.
- R5: When neither R1 nor R2 applies (for example, no write enable is set), the select is 2'b00, meaning the register-file value.
- R6: When `ex_is_load` is 1 and `ex_src_b` (the load destination) equals `id_src_a` or `id_src_b`, the block stalls in the same cycle: `pc_wr_en`=0, `ifid_wr_en`=0, `bubble_sel`=1.
- R7: While `bubble_sel` is 1, `idex_ctrl` is all zeros. Otherwise `idex_ctrl` equals `dec_ctrl`. The bundle layout is bit 8 dest-select, bits 7:6 ALU op, bit 5 ALU source, bit 4 branch, bit 3 mem read, bit 2 mem write, bit 1 mem-to-reg, bit 0 reg write.
- R8: With no load hazard (no load in execute, or no index match), `pc_wr_en`=1, `ifid_wr_en`=1 and `bubble_sel`=0.
- R9: A stall lasts exactly one cycle. In the cycle after a stall, no stall is raised even if the hazard inputs are unchanged.
- R10: After reset, with idle inputs, both selects are 2'b00, both write enables are 1 and `bubble_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the stall memory |
| rst_n | input | 1 | Active-low reset |
| ex_src_a | input | 5 | ID/EX first source register index |
| ex_src_b | input | 5 | ID/EX second source index (also the load destination) |
| ex_is_load | input | 1 | ID/EX memory-read flag |
| exm_dst | input | 5 | EX/MEM destination index |
| exm_wr_en | input | 1 | EX/MEM register-write flag |
| wbk_dst | input | 5 | MEM/WB destination index |
| wbk_wr_en | input | 1 | MEM/WB register-write flag |
| id_src_a | input | 5 | IF/ID first source index |
| id_src_b | input | 5 | IF/ID second source index |
| dec_ctrl | input | 9 | Control bundle from decode |
| fwd_sel_a | output | 2 | Operand A source select |
| fwd_sel_b | output | 2 | Operand B source select |
| pc_wr_en | output | 1 | Program counter write enable |
| ifid_wr_en | output | 1 | IF/ID register write enable |
| bubble_sel | output | 1 | Selects the zeroed control bundle |
| idex_ctrl | output | 9 | Control bundle into ID/EX |

## Verification
The forward selects, write enables, bubble select and the ID/EX control bundle all settle in the same cycle as the pipeline-register fields that cause them. The bench drives each step one time unit after a rising edge and compares the outputs at the following falling edge of that same cycle. The one exception is the single-cycle limit, which depends on the stall memory written at the next rising edge. The bench covers it by holding a hazard for two consecutive steps and expecting the stall only in the first.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;

   typedef enum logic [1:0] {
      FWD_REGFILE = 2'b00,
      FWD_MEMWB   = 2'b01,
      FWD_EXMEM   = 2'b10
   } fwd_src_e;

   typedef struct packed {
      logic reg_dst;
      logic alu_op1;
      logic alu_op0;
      logic alu_src;
      logic branch;
      logic mem_read;
      logic mem_write;
      logic mem_to_reg;
      logic reg_write;
   } ctrl_bundle_t;

   localparam int CTRL_BITS = $bits(ctrl_bundle_t);

endpackage

// File: rtl/phc_fwd_sel.sv
module phc_fwd_sel
   import pipe_hazard_pkg::*;
#(
   parameter int REG_W      = 5,
   parameter bit ZERO_GUARD = 1'b1
) (
   input  logic [REG_W-1:0] src_idx,
   input  logic [REG_W-1:0] near_dst,
   input  logic             near_wr,
   input  logic [REG_W-1:0] far_dst,
   input  logic             far_wr,
   output fwd_src_e         sel
);

   logic near_hit;
   logic far_hit;

   generate
      if (ZERO_GUARD) begin : g_guard
         assign near_hit = near_wr && (near_dst != '0) && (near_dst == src_idx);
         assign far_hit  = far_wr  && (far_dst  != '0) && (far_dst  == src_idx);
      end else begin : g_noguard
         assign near_hit = near_wr && (near_dst == src_idx);
         assign far_hit  = far_wr  && (far_dst  == src_idx);
      end
   endgenerate

   always_comb begin
      if (near_hit)     sel = FWD_EXMEM;
      else if (far_hit) sel = FWD_MEMWB;
      else              sel = FWD_REGFILE;
   end

endmodule

// File: rtl/phc_load_stall.sv
module phc_load_stall #(
   parameter int REG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ex_is_load,
   input  logic [REG_W-1:0] ex_load_dst,
   input  logic [REG_W-1:0] id_src_a,
   input  logic [REG_W-1:0] id_src_b,
   output logic             stall
);

   logic hazard;
   logic stall_q;

   assign hazard = ex_is_load &&
                   ((ex_load_dst == id_src_a) || (ex_load_dst == id_src_b));
   assign stall  = hazard && !stall_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stall_q <= 1'b0;
      else        stall_q <= stall;
   end

endmodule

// File: rtl/phc_bubble_mux.sv
module phc_bubble_mux
   import pipe_hazard_pkg::*;
(
   input  logic         stall,
   input  ctrl_bundle_t ctrl_in,
   output ctrl_bundle_t ctrl_out,
   output logic         pc_we,
   output logic         ifid_we,
   output logic         bubble
);

   assign bubble   = stall;
   assign pc_we    = !stall;
   assign ifid_we  = !stall;
   assign ctrl_out = stall ? '0 : ctrl_in;

endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
   import pipe_hazard_pkg::*;
#(
   parameter int REG_W      = 5,
   parameter bit ZERO_GUARD = 1'b1,
   parameter int CTRL_W     = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_W-1:0]  ex_src_a,
   input  logic [REG_W-1:0]  ex_src_b,
   input  logic              ex_is_load,
   input  logic [REG_W-1:0]  exm_dst,
   input  logic              exm_wr_en,
   input  logic [REG_W-1:0]  wbk_dst,
   input  logic              wbk_wr_en,
   input  logic [REG_W-1:0]  id_src_a,
   input  logic [REG_W-1:0]  id_src_b,
   input  logic [CTRL_W-1:0] dec_ctrl,
   output logic [1:0]        fwd_sel_a,
   output logic [1:0]        fwd_sel_b,
   output logic              pc_wr_en,
   output logic              ifid_wr_en,
   output logic              bubble_sel,
   output logic [CTRL_W-1:0] idex_ctrl
);

   localparam int NUM_OPS = 2;

   generate
      if (REG_W < 1) begin : g_bad_width
         $error("REG_W must be at least 1");
      end
      if (CTRL_W != CTRL_BITS) begin : g_bad_ctrl
         $error("CTRL_W must match the control bundle width");
      end
   endgenerate

   logic [REG_W-1:0] op_src [NUM_OPS];
   fwd_src_e         op_sel [NUM_OPS];

   assign op_src[0] = ex_src_a;
   assign op_src[1] = ex_src_b;

   generate
      for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
         phc_fwd_sel #(
            .REG_W      (REG_W),
            .ZERO_GUARD (ZERO_GUARD)
         ) u_fwd (
            .src_idx  (op_src[g]),
            .near_dst (exm_dst),
            .near_wr  (exm_wr_en),
            .far_dst  (wbk_dst),
            .far_wr   (wbk_wr_en),
            .sel      (op_sel[g])
         );
      end
   endgenerate

   assign fwd_sel_a = op_sel[0];
   assign fwd_sel_b = op_sel[1];

   logic         stall;
   ctrl_bundle_t ctrl_in;
   ctrl_bundle_t ctrl_out;

   phc_load_stall #(.REG_W(REG_W)) u_stall (
      .clk         (clk),
      .rst_n       (rst_n),
      .ex_is_load  (ex_is_load),
      .ex_load_dst (ex_src_b),
      .id_src_a    (id_src_a),
      .id_src_b    (id_src_b),
      .stall       (stall)
   );

   assign ctrl_in = ctrl_bundle_t'(dec_ctrl);

   phc_bubble_mux u_bubble (
      .stall    (stall),
      .ctrl_in  (ctrl_in),
      .ctrl_out (ctrl_out),
      .pc_we    (pc_wr_en),
      .ifid_we  (ifid_wr_en),
      .bubble   (bubble_sel)
   );

   assign idex_ctrl = ctrl_out;

endmodule

// File: rtl/phc_checker.sv
module phc_checker #(
   parameter int REG_W  = 5,
   parameter int CTRL_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic [REG_W-1:0]  ex_src_a,
   input logic [REG_W-1:0]  ex_src_b,
   input logic              ex_is_load,
   input logic [REG_W-1:0]  exm_dst,
   input logic              exm_wr_en,
   input logic [REG_W-1:0]  wbk_dst,
   input logic              wbk_wr_en,
   input logic [CTRL_W-1:0] idex_ctrl,
   input logic [1:0]        fwd_sel_a,
   input logic [1:0]        fwd_sel_b,
   input logic              pc_wr_en,
   input logic              ifid_wr_en,
   input logic              bubble_sel
);

   AST_EXMEM_WINS_A: assert property (@(posedge clk) disable iff (!rst_n)
      (exm_wr_en && exm_dst != '0 && exm_dst == ex_src_a) |-> fwd_sel_a == 2'b10); // R1

   AST_MEMWB_ONLY_B: assert property (@(posedge clk) disable iff (!rst_n)
      (!exm_wr_en && wbk_wr_en && wbk_dst != '0 && wbk_dst == ex_src_b) |-> fwd_sel_b == 2'b01); // R2

   AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fwd_sel_a) && $onehot0(fwd_sel_b)); // R3

   AST_NO_ZERO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      (exm_dst == '0 && wbk_dst == '0) |-> (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00)); // R4

   AST_STALL_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      bubble_sel |-> (!pc_wr_en && !ifid_wr_en && idex_ctrl == '0)); // R7

   AST_NO_LOAD_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_is_load |-> (pc_wr_en && ifid_wr_en && !bubble_sel)); // R8

   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      bubble_sel |=> !bubble_sel); // R9

endmodule

bind pipe_hazard_ctl phc_checker #(.REG_W(REG_W), .CTRL_W(CTRL_W)) u_chk (.*);

// File: tb/test_pipe_hazard_ctl.sv
`timescale 1ns/1ps
module test_pipe_hazard_ctl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] ex_src_a, ex_src_b, exm_dst, wbk_dst, id_src_a, id_src_b;
   logic       ex_is_load, exm_wr_en, wbk_wr_en;
   logic [8:0] dec_ctrl;
   logic [1:0] fwd_sel_a, fwd_sel_b;
   logic       pc_wr_en, ifid_wr_en, bubble_sel;
   logic [8:0] idex_ctrl;

   always #2.5 clk = ~clk;

   pipe_hazard_ctl i_pipe_hazard_ctl (
      .clk(clk), .rst_n(rst_n),
      .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_is_load(ex_is_load),
      .exm_dst(exm_dst), .exm_wr_en(exm_wr_en),
      .wbk_dst(wbk_dst), .wbk_wr_en(wbk_wr_en),
      .id_src_a(id_src_a), .id_src_b(id_src_b), .dec_ctrl(dec_ctrl),
      .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
      .pc_wr_en(pc_wr_en), .ifid_wr_en(ifid_wr_en),
      .bubble_sel(bubble_sel), .idex_ctrl(idex_ctrl)
   );

   typedef struct {
      logic [1:0] fa;
      logic [1:0] fb;
      logic       stall;
      logic [8:0] ctrl;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   n_run  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;
   bit   model_stall_prev = 1'b0;

   logic [4:0] s_ea, s_eb, s_xd, s_wd, s_ia, s_ib;
   logic       s_ld, s_xw, s_ww;
   logic [8:0] s_ctrl;

   function automatic logic [1:0] ref_fwd(input logic [4:0] src);
      if (s_xw && s_xd != 5'd0 && s_xd == src)      return 2'b10;
      else if (s_ww && s_wd != 5'd0 && s_wd == src) return 2'b01;
      else                                          return 2'b00;
   endfunction

   task automatic idle_stim();
      s_ea = 5'd1; s_eb = 5'd2; s_xd = 5'd3; s_wd = 5'd4;
      s_ia = 5'd5; s_ib = 5'd6; s_ld = 1'b0; s_xw = 1'b0; s_ww = 1'b0;
      s_ctrl = 9'h1A5;
   endtask

   task automatic step(input string tag);
      exp_t e;
      bit   haz;
      @(posedge clk);
      #1;
      ex_src_a = s_ea; ex_src_b = s_eb; exm_dst = s_xd; wbk_dst = s_wd;
      id_src_a = s_ia; id_src_b = s_ib; ex_is_load = s_ld;
      exm_wr_en = s_xw; wbk_wr_en = s_ww; dec_ctrl = s_ctrl;
      haz     = s_ld && (s_eb == s_ia || s_eb == s_ib);
      e.stall = haz && !model_stall_prev;
      model_stall_prev = e.stall;
      e.fa   = ref_fwd(s_ea);
      e.fb   = ref_fwd(s_eb);
      e.ctrl = e.stall ? 9'h000 : s_ctrl;
      e.tag  = tag;
      q.push_back(e);
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            e = q.pop_front();
            n_run++;
            if (fwd_sel_a !== e.fa || fwd_sel_b !== e.fb ||
                bubble_sel !== e.stall || pc_wr_en !== !e.stall ||
                ifid_wr_en !== !e.stall || idex_ctrl !== e.ctrl) begin
               n_fail++;
               $display("FAIL %s: got fa=%b fb=%b bub=%b pc=%b ifid=%b ctrl=%h exp fa=%b fb=%b bub=%b ctrl=%h",
                        e.tag, fwd_sel_a, fwd_sel_b, bubble_sel, pc_wr_en,
                        ifid_wr_en, idex_ctrl, e.fa, e.fb, e.stall, e.ctrl);
            end
         end
      end
   end

   initial begin : watchdog
      #100000;
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : driver
      idle_stim();
      ex_src_a = s_ea; ex_src_b = s_eb; exm_dst = s_xd; wbk_dst = s_wd;
      id_src_a = s_ia; id_src_b = s_ib; ex_is_load = s_ld;
      exm_wr_en = s_xw; wbk_wr_en = s_ww; dec_ctrl = s_ctrl;
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_run++;
      if (fwd_sel_a !== 2'b00 || fwd_sel_b !== 2'b00 || pc_wr_en !== 1'b1 ||
          ifid_wr_en !== 1'b1 || bubble_sel !== 1'b0) begin
         n_fail++;
         $display("FAIL R10: got fa=%b fb=%b pc=%b ifid=%b bub=%b exp 00 00 1 1 0",
                  fwd_sel_a, fwd_sel_b, pc_wr_en, ifid_wr_en, bubble_sel);
      end
      rst_n = 1'b1;

      idle_stim(); step("R10 idle after reset");
      idle_stim(); s_xd = 5'd1; s_wd = 5'd2; step("R5 match without write enable");
      idle_stim(); s_xw = 1'b1; s_xd = 5'd1; step("R1 exmem to operand A");
      idle_stim(); s_xw = 1'b1; s_xd = 5'd2; step("R1 exmem to operand B");
      idle_stim(); s_ww = 1'b1; s_wd = 5'd1; step("R2 memwb to operand A");
      idle_stim(); s_ww = 1'b1; s_wd = 5'd2; s_xw = 1'b1; s_xd = 5'd9;
      step("R2 memwb to B with exmem unrelated");
      idle_stim(); s_xw = 1'b1; s_ww = 1'b1; s_xd = 5'd1; s_wd = 5'd1;
      step("R3 both stages match A");
      idle_stim(); s_ea = 5'd7; s_eb = 5'd7; s_xw = 1'b1; s_ww = 1'b1;
      s_xd = 5'd7; s_wd = 5'd7; step("R3 both stages match both operands");
      idle_stim(); s_xw = 1'b1; s_xd = 5'd1; s_ww = 1'b1; s_wd = 5'd2;
      step("R1 R2 split A from exmem B from memwb");
      idle_stim(); s_ea = 5'd0; s_eb = 5'd0; s_xw = 1'b1; s_ww = 1'b1;
      s_xd = 5'd0; s_wd = 5'd0; step("R4 register zero not forwarded");
      idle_stim(); s_ea = 5'd0; s_xw = 1'b1; s_xd = 5'd0; s_ww = 1'b1; s_wd = 5'd0;
      s_eb = 5'd0; step("R4 zero with both writes");
      idle_stim(); s_ld = 1'b1; s_eb = 5'd5; s_ctrl = 9'h1FF;
      step("R6 R7 load-use on decode src A");
      step("R9 held hazard gives no second stall");
      idle_stim(); s_ld = 1'b1; s_eb = 5'd6; s_ctrl = 9'h0C3;
      step("R6 R7 load-use on decode src B");
      idle_stim(); s_ctrl = 9'h0C3; step("R8 R7 after stall pipeline runs");
      idle_stim(); s_ld = 1'b1; s_eb = 5'd12; step("R8 load without dependency");
      idle_stim(); s_eb = 5'd5; step("R8 match without load");
      idle_stim(); s_ld = 1'b1; s_eb = 5'd5; s_xw = 1'b1; s_xd = 5'd5;
      step("R6 stall with concurrent forwarding");
      idle_stim(); step("R8 release");

      @(negedge clk);
      #1;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule